// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block keeps three vector bitmaps, one bit per interrupt vector: one for requests that are waiting, one for vectors a core is servicing now, and one for the trigger mode of each vector. Interrupt sources post a vector together with a trigger-mode flag. The controller presents the highest waiting vector to the core only if that vector's priority class (its upper four bits) is above the current processor priority. The processor priority is derived from a task priority written by software and from the highest vector in service.

The core takes the presented vector with an acknowledge strobe, which moves the vector from waiting to in service. When the core writes an end-of-interrupt, the controller retires the highest vector in service. If that vector was level-triggered, the controller emits a one-cycle broadcast that carries the vector, so the level source can be re-armed. The task priority can be written through a full 8-bit port or through a 4-bit alias that maps to its upper nibble. All outputs are registered and show the state after the most recent clock edge.

Top module: `vec_prio_ctrl`

## Requirements
- R1: A synchronous active-high reset empties all three bitmaps and sets the task priority to 0. After the reset edge, irq_valid_o, bcast_valid_o, ppr_o and tpr_o are all 0.
- R2: ppr_o equals tpr_o when tpr_o[7:4] is at least the upper nibble of the highest in-service vector (taken as 0 when nothing is in service). Otherwise ppr_o is that vector's upper nibble with the low nibble 0.
- R3: irq_valid_o is 1, with irq_vec_o equal to the numerically highest waiting vector, exactly when enable_i was 1 at the updating edge and that vector's upper nibble, followed by four zero bits, is strictly greater than ppr_o. Otherwise irq_valid_o is 0.
- R4: An acknowledge while irq_valid_o is 1 clears the offered vector's waiting bit and sets its in-service bit. An acknowledge while irq_valid_o is 0 changes nothing.
- R5: An end-of-interrupt clears the in-service bit of the highest in-service vector and the priority is recomputed. An end-of-interrupt with nothing in service changes nothing.
- R6: If the retired vector's trigger-mode bit was 1, that bit is cleared and bcast_valid_o is 1 for exactly the cycle after the end-of-interrupt, with bcast_vec_o equal to the retired vector. Otherwise bcast_valid_o stays 0.
- R7: An accepted request sets the vector's waiting bit and writes its trigger-mode bit: 1 for req_level_i = 1 (level), 0 for req_level_i = 0 (edge).
- R8: A level request for a vector that is already waiting is dropped and leaves its trigger-mode bit unchanged. An edge request for a waiting vector clears that bit.
- R9: While enable_i is 0, requests are ignored and irq_valid_o is 0 after the next edge.
- R10: When a request and an acknowledge fall in the same cycle, the acknowledge acts on the state from before the request, and the request is then judged against the state the acknowledge left. An end-of-interrupt in the same cycle retires the in-service vector that was highest before the acknowledge.
- R11: alias_wr_i writes {alias_wdata_i, 4'b0000} into the task priority, and alias_o always reads tpr_o[7:4]. If tpr_wr_i and alias_wr_i are both 1, tpr_wr_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Controller enable; gates requests and the offer |
| req_valid_i | input | 1 | Interrupt request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_wr_i | input | 1 | Full task-priority write strobe |
| tpr_wdata_i | input | 8 | Task-priority write data |
| alias_wr_i | input | 1 | 4-bit alias write strobe |
| alias_wdata_i | input | 4 | Alias data, lands in task priority [7:4] |
| ack_i | input | 1 | Core acknowledges the offered vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_valid_o | output | 1 | A vector is offered to the core |
| irq_vec_o | output | 8 | Offered vector |
| ppr_o | output | 8 | Processor priority |
| tpr_o | output | 8 | Task priority |
| alias_o | output | 4 | Alias read value, tpr_o[7:4] |
| bcast_valid_o | output | 1 | End-of-interrupt broadcast pulse for a level vector |
| bcast_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
Two functions can fall in the same cycle: an acknowledge of the offered vector and a new request for that same vector, and also an acknowledge together with an end-of-interrupt. The bench forces an acknowledge and a level request on the same vector in one cycle. It expects the request to be accepted again rather than dropped, which is then visible as a broadcast on the following end-of-interrupt. A long random phase drives requests, acknowledges, end-of-interrupts and priority writes densely enough that every pair coincides often. On every clock it compares all outputs against a behavioural model that applies the end-of-interrupt, then the acknowledge, then the request.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  localparam int VPC_NUM_VEC = 256;
  localparam int VPC_WORD_W  = 32;
  localparam int VPC_CLASS_W = 4;

  typedef enum logic [1:0] {
    TPR_HOLD  = 2'd0,
    TPR_FULL  = 2'd1,
    TPR_ALIAS = 2'd2
  } tpr_src_e;

endpackage

// File: rtl/vpc_msb_search.sv
module vpc_msb_search #(
  parameter int NUM_BITS = 256,
  parameter int WORD_W   = 32,
  parameter int IDX_W    = 8
) (
  input  logic [NUM_BITS-1:0] bits_i,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o
);

  localparam int NUM_WORDS = NUM_BITS / WORD_W;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [NUM_WORDS-1:0] word_any;
  logic [BIT_W-1:0]     word_msb [NUM_WORDS];

  // Per-word scan: any-bit flag and index of the most significant set bit.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] slice;
    logic [BIT_W-1:0]  msb;

    assign slice = bits_i[w*WORD_W +: WORD_W];

    always_comb begin
      msb = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (slice[b]) msb = BIT_W'(b);
      end
    end

    assign word_any[w] = |slice;
    assign word_msb[w] = msb;
  end

  // Word selection: the highest word with any bit set wins.
  logic [WSEL_W-1:0] sel;

  always_comb begin
    found_o = 1'b0;
    sel     = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_any[w]) begin
        found_o = 1'b1;
        sel     = WSEL_W'(w);
      end
    end
  end

  assign idx_o = IDX_W'({sel, word_msb[sel]});

endmodule

// File: rtl/vpc_priority.sv
module vpc_priority #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic             enable_i,
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_found_i,
  input  logic [VEC_W-1:0] isr_vec_i,
  input  logic             irr_found_i,
  input  logic [VEC_W-1:0] irr_vec_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             offer_valid_o,
  output logic [VEC_W-1:0] offer_vec_o
);

  localparam int SUB_W = VEC_W - CLASS_W;

  logic [CLASS_W-1:0] tpr_class;
  logic [CLASS_W-1:0] isr_class;
  logic [VEC_W-1:0]   irr_floor;

  assign tpr_class = tpr_i[VEC_W-1:SUB_W];
  assign isr_class = isr_found_i ? isr_vec_i[VEC_W-1:SUB_W] : '0;

  // Task priority stands unless the servicing class is above it.
  always_comb begin
    if (tpr_class >= isr_class) ppr_o = tpr_i;
    else                        ppr_o = {isr_class, {SUB_W{1'b0}}};
  end

  // Class of the best waiting vector, low bits cleared, against ppr.
  assign irr_floor     = {irr_vec_i[VEC_W-1:SUB_W], {SUB_W{1'b0}}};
  assign offer_valid_o = enable_i && irr_found_i && (irr_floor > ppr_o);
  assign offer_vec_o   = irr_vec_i;

endmodule

// File: rtl/vpc_bitmap_next.sv
module vpc_bitmap_next #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8
) (
  input  logic [NUM_VEC-1:0] irr_q_i,
  input  logic [NUM_VEC-1:0] isr_q_i,
  input  logic [NUM_VEC-1:0] tmr_q_i,
  input  logic               eoi_fire_i,
  input  logic [VEC_W-1:0]   eoi_vec_i,
  input  logic               ack_fire_i,
  input  logic [VEC_W-1:0]   ack_vec_i,
  input  logic               req_fire_i,
  input  logic [VEC_W-1:0]   req_vec_i,
  input  logic               req_level_i,
  output logic [NUM_VEC-1:0] irr_d_o,
  output logic [NUM_VEC-1:0] isr_d_o,
  output logic [NUM_VEC-1:0] tmr_d_o,
  output logic               bcast_o
);

  // Fixed order inside one cycle: retire, then acknowledge, then request.
  always_comb begin
    irr_d_o = irr_q_i;
    isr_d_o = isr_q_i;
    tmr_d_o = tmr_q_i;
    bcast_o = 1'b0;

    if (eoi_fire_i) begin
      isr_d_o[eoi_vec_i] = 1'b0;
      if (tmr_q_i[eoi_vec_i]) begin
        tmr_d_o[eoi_vec_i] = 1'b0;
        bcast_o            = 1'b1;
      end
    end

    if (ack_fire_i) begin
      isr_d_o[ack_vec_i] = 1'b1;
      irr_d_o[ack_vec_i] = 1'b0;
    end

    if (req_fire_i) begin
      if (!(irr_d_o[req_vec_i] && req_level_i)) begin
        irr_d_o[req_vec_i] = 1'b1;
        tmr_d_o[req_vec_i] = req_level_i;
      end
    end
  end

endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int NUM_VEC = VPC_NUM_VEC,
  parameter int WORD_W  = VPC_WORD_W,
  parameter int CLASS_W = VPC_CLASS_W,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int SUB_W  = VEC_W - CLASS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable_i,
  input  logic               req_valid_i,
  input  logic [VEC_W-1:0]   req_vec_i,
  input  logic               req_level_i,
  input  logic               tpr_wr_i,
  input  logic [VEC_W-1:0]   tpr_wdata_i,
  input  logic               alias_wr_i,
  input  logic [CLASS_W-1:0] alias_wdata_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               irq_valid_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic [VEC_W-1:0]   ppr_o,
  output logic [VEC_W-1:0]   tpr_o,
  output logic [CLASS_W-1:0] alias_o,
  output logic               bcast_valid_o,
  output logic [VEC_W-1:0]   bcast_vec_o
);

  // State
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [VEC_W-1:0]   tpr_q, ppr_q;
  logic               offer_valid_q, isr_top_valid_q, bcast_valid_q;
  logic [VEC_W-1:0]   offer_vec_q, isr_top_vec_q, bcast_vec_q;

  // Strobes qualified by current state
  logic ack_fire, eoi_fire, req_fire;

  assign ack_fire = ack_i && offer_valid_q;
  assign eoi_fire = eoi_i && isr_top_valid_q;
  assign req_fire = req_valid_i && enable_i;

  // Task priority next value
  tpr_src_e         tpr_src;
  logic [VEC_W-1:0] tpr_d;

  always_comb begin
    if (tpr_wr_i)        tpr_src = TPR_FULL;
    else if (alias_wr_i) tpr_src = TPR_ALIAS;
    else                 tpr_src = TPR_HOLD;
  end

  always_comb begin
    unique case (tpr_src)
      TPR_FULL:  tpr_d = tpr_wdata_i;
      TPR_ALIAS: tpr_d = {alias_wdata_i, {SUB_W{1'b0}}};
      default:   tpr_d = tpr_q;
    endcase
  end

  // Bitmap next state
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  logic               bcast_d;

  vpc_bitmap_next #(
    .NUM_VEC (NUM_VEC),
    .VEC_W   (VEC_W)
  ) u_next (
    .irr_q_i     (irr_q),
    .isr_q_i     (isr_q),
    .tmr_q_i     (tmr_q),
    .eoi_fire_i  (eoi_fire),
    .eoi_vec_i   (isr_top_vec_q),
    .ack_fire_i  (ack_fire),
    .ack_vec_i   (offer_vec_q),
    .req_fire_i  (req_fire),
    .req_vec_i   (req_vec_i),
    .req_level_i (req_level_i),
    .irr_d_o     (irr_d),
    .isr_d_o     (isr_d),
    .tmr_d_o     (tmr_d),
    .bcast_o     (bcast_d)
  );

  // Searches on the next bitmaps, so registered outputs match the new state
  logic             irr_found, isr_found;
  logic [VEC_W-1:0] irr_top, isr_top;

  vpc_msb_search #(
    .NUM_BITS (NUM_VEC),
    .WORD_W   (WORD_W),
    .IDX_W    (VEC_W)
  ) u_irr_search (
    .bits_i  (irr_d),
    .found_o (irr_found),
    .idx_o   (irr_top)
  );

  vpc_msb_search #(
    .NUM_BITS (NUM_VEC),
    .WORD_W   (WORD_W),
    .IDX_W    (VEC_W)
  ) u_isr_search (
    .bits_i  (isr_d),
    .found_o (isr_found),
    .idx_o   (isr_top)
  );

  logic [VEC_W-1:0] ppr_d, offer_vec_d;
  logic             offer_valid_d;

  vpc_priority #(
    .VEC_W   (VEC_W),
    .CLASS_W (CLASS_W)
  ) u_prio (
    .enable_i      (enable_i),
    .tpr_i         (tpr_d),
    .isr_found_i   (isr_found),
    .isr_vec_i     (isr_top),
    .irr_found_i   (irr_found),
    .irr_vec_i     (irr_top),
    .ppr_o         (ppr_d),
    .offer_valid_o (offer_valid_d),
    .offer_vec_o   (offer_vec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q           <= '0;
      isr_q           <= '0;
      tmr_q           <= '0;
      tpr_q           <= '0;
      ppr_q           <= '0;
      offer_valid_q   <= 1'b0;
      offer_vec_q     <= '0;
      isr_top_valid_q <= 1'b0;
      isr_top_vec_q   <= '0;
      bcast_valid_q   <= 1'b0;
      bcast_vec_q     <= '0;
    end else begin
      irr_q           <= irr_d;
      isr_q           <= isr_d;
      tmr_q           <= tmr_d;
      tpr_q           <= tpr_d;
      ppr_q           <= ppr_d;
      offer_valid_q   <= offer_valid_d;
      offer_vec_q     <= offer_vec_d;
      isr_top_valid_q <= isr_found;
      isr_top_vec_q   <= isr_top;
      bcast_valid_q   <= bcast_d;
      if (bcast_d) bcast_vec_q <= isr_top_vec_q;
    end
  end

  assign irq_valid_o   = offer_valid_q;
  assign irq_vec_o     = offer_vec_q;
  assign ppr_o         = ppr_q;
  assign tpr_o         = tpr_q;
  assign alias_o       = tpr_q[VEC_W-1:SUB_W];
  assign bcast_valid_o = bcast_valid_q;
  assign bcast_vec_o   = bcast_vec_q;

endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             enable_i,
  input logic             ack_i,
  input logic             eoi_i,
  input logic             irq_valid_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [VEC_W-1:0] ppr_o,
  input logic [VEC_W-1:0] tpr_o,
  input logic             bcast_valid_o
);

  localparam int SUB_W = VEC_W - CLASS_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!irq_valid_o && !bcast_valid_o && ppr_o == '0 && tpr_o == '0));

  // R2
  ppr_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (ppr_o[VEC_W-1:SUB_W] >= tpr_o[VEC_W-1:SUB_W]) &&
    ((ppr_o == tpr_o) || (ppr_o[SUB_W-1:0] == '0)));

  // R3
  offer_above_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (irq_vec_o[VEC_W-1:SUB_W] > ppr_o[VEC_W-1:SUB_W]));

  // R4
  ack_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_valid_o) |=> (ppr_o[VEC_W-1:SUB_W] >= $past(irq_vec_o[VEC_W-1:SUB_W])));

  // R6
  bcast_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!eoi_i) |=> !bcast_valid_o);

  // R9
  disabled_no_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable_i) |=> !irq_valid_o);

endmodule

bind vec_prio_ctrl vpc_checker #(
  .VEC_W   (VEC_W),
  .CLASS_W (CLASS_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .enable_i      (enable_i),
  .ack_i         (ack_i),
  .eoi_i         (eoi_i),
  .irq_valid_o   (irq_valid_o),
  .irq_vec_o     (irq_vec_o),
  .ppr_o         (ppr_o),
  .tpr_o         (tpr_o),
  .bcast_valid_o (bcast_valid_o)
);

// File: tb/vec_prio_ctrl_tb_top.sv
module vec_prio_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable_i = 1'b1;
  logic       req_valid_i = 1'b0;
  logic [7:0] req_vec_i = '0;
  logic       req_level_i = 1'b0;
  logic       tpr_wr_i = 1'b0;
  logic [7:0] tpr_wdata_i = '0;
  logic       alias_wr_i = 1'b0;
  logic [3:0] alias_wdata_i = '0;
  logic       ack_i = 1'b0;
  logic       eoi_i = 1'b0;
  logic       irq_valid_o;
  logic [7:0] irq_vec_o;
  logic [7:0] ppr_o;
  logic [7:0] tpr_o;
  logic [3:0] alias_o;
  logic       bcast_valid_o;
  logic [7:0] bcast_vec_o;

  always #5 clk = ~clk;

  vec_prio_ctrl dut_i (
    .clk           (clk),
    .rst           (rst),
    .enable_i      (enable_i),
    .req_valid_i   (req_valid_i),
    .req_vec_i     (req_vec_i),
    .req_level_i   (req_level_i),
    .tpr_wr_i      (tpr_wr_i),
    .tpr_wdata_i   (tpr_wdata_i),
    .alias_wr_i    (alias_wr_i),
    .alias_wdata_i (alias_wdata_i),
    .ack_i         (ack_i),
    .eoi_i         (eoi_i),
    .irq_valid_o   (irq_valid_o),
    .irq_vec_o     (irq_vec_o),
    .ppr_o         (ppr_o),
    .tpr_o         (tpr_o),
    .alias_o       (alias_o),
    .bcast_valid_o (bcast_valid_o),
    .bcast_vec_o   (bcast_vec_o)
  );

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [255:0] m_pend, m_serv, m_lvl;
  int           m_tpr;
  bit           e_irq_v, e_bc_v, started = 1'b0;
  int           e_irq_vec, e_ppr, e_bc_vec;

  function automatic int top_bit(input logic [255:0] m);
    for (int i = 255; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int calc_ppr(input int tpr, input logic [255:0] serv);
    int h = top_bit(serv);
    int hv = (h < 0) ? 0 : h;
    if ((tpr & 8'hF0) >= (hv & 8'hF0)) return tpr;
    return hv & 8'hF0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_serv = '0; m_lvl = '0; m_tpr = 0;
      e_irq_v = 0; e_irq_vec = 0; e_ppr = 0; e_bc_v = 0;
      started = 1'b1;
    end else if (started) begin
      int  h;
      bit  acked;
      int  av;
      acked = ack_i && e_irq_v;
      av    = e_irq_vec;
      h     = top_bit(m_serv);
      e_bc_v = 0;
      if (eoi_i && h >= 0) begin
        m_serv[h] = 1'b0;
        if (m_lvl[h]) begin
          m_lvl[h] = 1'b0;
          e_bc_v   = 1;
          e_bc_vec = h;
        end
      end
      if (acked) begin
        m_serv[av] = 1'b1;
        m_pend[av] = 1'b0;
      end
      if (req_valid_i && enable_i) begin
        if (!(m_pend[req_vec_i] && req_level_i)) begin
          m_pend[req_vec_i] = 1'b1;
          m_lvl[req_vec_i]  = req_level_i;
        end
      end
      if (tpr_wr_i)        m_tpr = tpr_wdata_i;
      else if (alias_wr_i) m_tpr = {alias_wdata_i, 4'h0};
      e_ppr = calc_ppr(m_tpr, m_serv);
      h     = top_bit(m_pend);
      e_irq_v   = enable_i && (h >= 0) && ((h & 8'hF0) > e_ppr);
      e_irq_vec = (h < 0) ? 0 : h;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !rst && !finished) begin
      check(ppr_o == 8'(e_ppr), "R2 ppr", ppr_o, e_ppr);
      check(irq_valid_o == e_irq_v, "R3 offer valid", irq_valid_o, e_irq_v);
      if (e_irq_v) check(irq_vec_o == 8'(e_irq_vec), "R3 offer vector", irq_vec_o, e_irq_vec);
      check(tpr_o == 8'(m_tpr) && alias_o == 4'(m_tpr >> 4), "R11 tpr/alias", tpr_o, m_tpr);
      check(bcast_valid_o == e_bc_v, "R6 bcast valid", bcast_valid_o, e_bc_v);
      if (e_bc_v) check(bcast_vec_o == 8'(e_bc_vec), "R6 bcast vector", bcast_vec_o, e_bc_vec);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
    req_valid_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0;
    tpr_wr_i = 1'b0; alias_wr_i = 1'b0;
  endtask

  task automatic post(input logic [7:0] v, input logic lvl);
    req_valid_i = 1'b1; req_vec_i = v; req_level_i = lvl;
  endtask

  task automatic expect_out(input string tag, input bit iv, input int ivec, input int ppr);
    check(irq_valid_o == iv, tag, irq_valid_o, iv);
    if (iv) check(irq_vec_o == 8'(ivec), tag, irq_vec_o, ivec);
    check(ppr_o == 8'(ppr), tag, ppr_o, ppr);
  endtask

  task automatic expect_bc(input string tag, input bit bv, input int bvec);
    check(bcast_valid_o == bv, tag, bcast_valid_o, bv);
    if (bv) check(bcast_vec_o == 8'(bvec), tag, bcast_vec_o, bvec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    check(!irq_valid_o && !bcast_valid_o, "R1 outputs idle", irq_valid_o, 0);
    check(ppr_o == 0 && tpr_o == 0, "R1 priorities zero", {ppr_o, tpr_o}, 0);

    post(8'h45, 1'b0); step(); expect_out("R7 edge request offered", 1, 8'h45, 0);
    post(8'h62, 1'b1); step(); expect_out("R3 higher vector wins", 1, 8'h62, 0);
    tpr_wr_i = 1'b1; tpr_wdata_i = 8'h70; step(); expect_out("R3 masked by task priority", 0, 0, 8'h70);
    tpr_wr_i = 1'b1; tpr_wdata_i = 8'h35; step(); expect_out("R2 task priority used", 1, 8'h62, 8'h35);
    ack_i = 1'b1; step(); expect_out("R4 ack raises ppr", 0, 0, 8'h60);
    ack_i = 1'b1; step(); expect_out("R4 ack without offer ignored", 0, 0, 8'h60);
    eoi_i = 1'b1; step();
    expect_out("R5 eoi retires service", 1, 8'h45, 8'h35);
    expect_bc("R6 level vector broadcast", 1, 8'h62);
    step(); expect_bc("R6 broadcast is one pulse", 0, 0);
    ack_i = 1'b1; step(); expect_out("R4 ack of 0x45", 0, 0, 8'h40);
    eoi_i = 1'b1; step(); expect_bc("R6 edge vector no broadcast", 0, 0);
    eoi_i = 1'b1; step();
    expect_bc("R5 eoi with empty service", 0, 0);
    expect_out("R5 empty eoi keeps ppr", 0, 0, 8'h35);

    // R8: level request on a waiting edge vector is dropped
    post(8'h90, 1'b0); step();
    post(8'h90, 1'b1); step();
    ack_i = 1'b1; step();
    eoi_i = 1'b1; step(); expect_bc("R8 dropped level request", 0, 0);
    // R8: edge request clears a waiting level vector's trigger bit
    post(8'hA0, 1'b1); step();
    post(8'hA0, 1'b0); step();
    ack_i = 1'b1; step();
    eoi_i = 1'b1; step(); expect_bc("R8 edge clears trigger", 0, 0);

    // R9: disabled controller ignores requests
    enable_i = 1'b0; post(8'hC0, 1'b0); step();
    expect_out("R9 no offer while disabled", 0, 0, 8'h35);
    enable_i = 1'b1; step();
    expect_out("R9 request was ignored", 0, 0, 8'h35);

    // R10: acknowledge and request on the same vector in one cycle
    post(8'hD0, 1'b0); step(); expect_out("R10 setup", 1, 8'hD0, 8'h35);
    ack_i = 1'b1; post(8'hD0, 1'b1); step();
    expect_out("R10 ack then request", 0, 0, 8'hD0);
    eoi_i = 1'b1; step();
    expect_bc("R10 re-request kept as level", 1, 8'hD0);
    expect_out("R10 vector offered again", 1, 8'hD0, 8'h35);
    ack_i = 1'b1; step();
    eoi_i = 1'b1; step();

    // R11: alias access and write precedence
    alias_wr_i = 1'b1; alias_wdata_i = 4'h9; step();
    check(tpr_o == 8'h90 && alias_o == 4'h9, "R11 alias write", tpr_o, 8'h90);
    tpr_wr_i = 1'b1; tpr_wdata_i = 8'h12; alias_wr_i = 1'b1; alias_wdata_i = 4'hF; step();
    check(tpr_o == 8'h12 && alias_o == 4'h1, "R11 full write wins", tpr_o, 8'h12);

    // Random phase, judged by the per-cycle model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 45) post(8'($urandom_range(16, 255)), 1'($urandom_range(0, 1)));
      ack_i    = ($urandom_range(0, 99) < 40);
      eoi_i    = ($urandom_range(0, 99) < 30);
      enable_i = ($urandom_range(0, 99) < 92);
      if ($urandom_range(0, 99) < 4) begin tpr_wr_i = 1'b1; tpr_wdata_i = 8'($urandom_range(0, 255)); end
      if ($urandom_range(0, 99) < 3) begin alias_wr_i = 1'b1; alias_wdata_i = 4'($urandom_range(0, 15)); end
      step();
    end
    finish_run();
  end

endmodule